// File: doc/BRIEF.md
# Dual-Clock Power Mode Controller

This block picks the system clock for a small controller that has two oscillators: a fast main oscillator and a 32.768 kHz sub-oscillator. It also runs the controller through two sleep depths. In the light sleep (hold), the CPU halts and the main oscillator is switched off, but the sub-oscillator keeps running. This lets timer and divider interrupts, which are clocked from the sub-clock, wake the part. In the deep sleep (stop), both oscillators are off. Only an enabled edge event on one of two designated 4-bit input ports can end it.

The oscillators are not modelled as analog cells. Each one appears as an enable output plus a tick input. A tick is a one-cycle pulse in the `clk` domain that marks one period of that oscillator. After any wake-up, the CPU clock gate stays closed until a programmable number of ticks of the selected clock have arrived. A single-cycle wake pulse goes to the interrupt controller at the moment of wake-up. While the CPU runs, an instruction-cycle enable fires once for every four periods of the selected system clock.

Top module: `pwr_clk_ctrl`

## Requirements
- R1: After reset the outputs are as follows. `cpu_clk_en`, `main_osc_en` and `sub_osc_en` are 1. `sys_sel_sub`, `xtal_mode`, `wake_pulse` and `cyc_en` are 0.
- R2: A configuration write has these fields. Bit 0 selects the clock: 1 selects the sub-clock, 0 selects the main clock. Bit 1 is the main-oscillator enable. Bit 2 selects crystal mode (1) or RC mode (0). After a write, `sys_sel_sub` follows bit 0 and `xtal_mode` follows bit 2.
- R3: A write that clears bit 1 while bit 0 selects the main clock leaves the main oscillator enabled. A write with bit 0 = 1 and bit 1 = 0 turns `main_osc_en` off.
- R4: While running, `cyc_en` pulses for one cycle after every 4th tick of the selected clock. Ticks of the unselected clock do not advance it.
- R5: A hold request drops `cpu_clk_en` and `main_osc_en` and keeps `sub_osc_en` at 1.
- R6: Hold ends only on an interrupt request whose enable bit is set. A masked interrupt and a port wake event both leave the block in hold.
- R7: A stop request drops `cpu_clk_en`, `main_osc_en` and `sub_osc_en`. Stop ends only on an enabled port wake bit (bits 3:0 are the first port, bits 7:4 the second). Interrupts and masked port bits leave the block in stop.
- R8: A wake-up raises `wake_pulse` for exactly one cycle. The oscillators are re-enabled from that cycle, with the main oscillator following the configured enable.
- R9: After a wake-up, `cpu_clk_en` rises only once STAB_TICKS ticks of the selected clock have been seen (4 by default). Ticks of the other clock do not count.
- R10: When a hold request and a stop request arrive together, stop wins.
- R11: Configuration writes made while the CPU is not running are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock for the control logic |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_data | input | 3 | Configuration value: {crystal, main enable, select sub} |
| hold_req | input | 1 | Request to enter hold |
| stop_req | input | 1 | Request to enter stop |
| port_wake | input | 8 | Edge events from the two wake ports |
| port_wake_en | input | 8 | Per-pin wake enables |
| irq_req | input | 8 | Interrupt requests |
| irq_en | input | 8 | Interrupt enables |
| main_tick | input | 1 | One pulse per main-oscillator period |
| sub_tick | input | 1 | One pulse per sub-oscillator period |
| main_osc_en | output | 1 | Main oscillator enable |
| sub_osc_en | output | 1 | Sub-oscillator enable |
| sys_sel_sub | output | 1 | System clock select (1 = sub-clock) |
| xtal_mode | output | 1 | Main oscillator crystal mode |
| cpu_clk_en | output | 1 | CPU clock gate |
| cyc_en | output | 1 | Instruction-cycle enable |
| wake_pulse | output | 1 | One-cycle wake indication |

## Verification
The bench targets the following cases, each with the fault it would expose:
- Turning off the main oscillator while it is still selected. A design that obeys that write would kill the main oscillator and leave `main_osc_en` at 0.
- Wake sources applied in the wrong sleep depth. A design that mixes up the wake sources would leave hold on a port event, or leave stop on an interrupt.
- Warm-up counting. A design that counts the wrong clock would reopen the CPU gate while ticks of the unselected oscillator are arriving, and a design off by one would reopen it one tick early or late.
- Arbitration and gated writes. A design that let hold win over stop would leave `sub_osc_en` at 1. A design that accepted configuration writes during sleep would come back from stop with a changed clock select.

// File: rtl/pcc_pkg.sv
package pcc_pkg;
  typedef enum logic [1:0] {
    PM_RUN  = 2'd0,
    PM_HOLD = 2'd1,
    PM_STOP = 2'd2,
    PM_WARM = 2'd3
  } pm_state_t;

  localparam int CFG_W = 3;
  localparam int CFG_SEL_SUB = 0;
  localparam int CFG_MAIN_EN = 1;
  localparam int CFG_XTAL = 2;
endpackage

// File: rtl/pcc_cfg.sv
module pcc_cfg
  import pcc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [CFG_W-1:0] wr_data,
  output logic             sel_sub,
  output logic             main_en,
  output logic             xtal
);
  always_ff @(posedge clk) begin
    if (rst) begin
      sel_sub <= 1'b0;
      main_en <= 1'b1;
      xtal    <= 1'b0;
    end else if (wr_en) begin
      sel_sub <= wr_data[CFG_SEL_SUB];
      // the main oscillator may only stop while the sub-clock is selected
      main_en <= wr_data[CFG_MAIN_EN] | ~wr_data[CFG_SEL_SUB];
      xtal    <= wr_data[CFG_XTAL];
    end
  end

  // R3
  main_kept_chk: assert property (@(posedge clk) disable iff (rst)
    !main_en |-> sel_sub);
endmodule

// File: rtl/pcc_seq.sv
module pcc_seq
  import pcc_pkg::*;
#(
  parameter int STAB_TICKS = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic hold_req,
  input  logic stop_req,
  input  logic port_hit,
  input  logic irq_hit,
  input  logic sel_sub,
  input  logic main_en,
  input  logic main_tick,
  input  logic sub_tick,
  output logic main_osc_en,
  output logic sub_osc_en,
  output logic cpu_clk_en,
  output logic wake_pulse
);
  localparam int CW = (STAB_TICKS > 1) ? $clog2(STAB_TICKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(STAB_TICKS - 1);

  pm_state_t state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic wake_d;
  logic sys_tick;

  assign sys_tick = sel_sub ? sub_tick : main_tick;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    wake_d  = 1'b0;
    case (state_q)
      PM_RUN: begin
        if (stop_req)      state_d = PM_STOP;
        else if (hold_req) state_d = PM_HOLD;
      end
      PM_HOLD: if (irq_hit) begin
        state_d = PM_WARM;
        cnt_d   = '0;
        wake_d  = 1'b1;
      end
      PM_STOP: if (port_hit) begin
        state_d = PM_WARM;
        cnt_d   = '0;
        wake_d  = 1'b1;
      end
      default: if (sys_tick) begin
        if (cnt_q == LAST) state_d = PM_RUN;
        else               cnt_d = cnt_q + 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= PM_RUN;
      cnt_q       <= '0;
      cpu_clk_en  <= 1'b1;
      sub_osc_en  <= 1'b1;
      main_osc_en <= 1'b1;
      wake_pulse  <= 1'b0;
    end else begin
      state_q     <= state_d;
      cnt_q       <= cnt_d;
      cpu_clk_en  <= (state_d == PM_RUN);
      sub_osc_en  <= (state_d != PM_STOP);
      main_osc_en <= ((state_d == PM_RUN) || (state_d == PM_WARM)) && main_en;
      wake_pulse  <= wake_d;
    end
  end

  // R5
  hold_osc_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == PM_HOLD) |-> (sub_osc_en && !cpu_clk_en && !main_osc_en));
  // R7
  stop_stays_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == PM_STOP && !port_hit) |=> (state_q == PM_STOP));
  // R8
  wake_single_chk: assert property (@(posedge clk) disable iff (rst)
    wake_pulse |=> !wake_pulse);
  // R9
  resume_warm_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(cpu_clk_en) |-> ($past(state_q) == PM_WARM));
endmodule

// File: rtl/pcc_cycdiv.sv
module pcc_cycdiv #(
  parameter int CYC_DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic sys_tick,
  output logic cyc_en
);
  localparam int PW = (CYC_DIV > 1) ? $clog2(CYC_DIV) : 1;
  localparam logic [PW-1:0] PLAST = PW'(CYC_DIV - 1);

  logic [PW-1:0] phase_q;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      phase_q <= '0;
      cyc_en  <= 1'b0;
    end else begin
      cyc_en <= sys_tick && (phase_q == PLAST);
      if (sys_tick) phase_q <= (phase_q == PLAST) ? '0 : phase_q + 1'b1;
    end
  end

  // R4
  cyc_single_chk: assert property (@(posedge clk) disable iff (rst)
    cyc_en |=> !cyc_en);
endmodule

// File: rtl/pwr_clk_ctrl.sv
module pwr_clk_ctrl
  import pcc_pkg::*;
#(
  parameter int PORT_W     = 4,
  parameter int NPORT      = 2,
  parameter int NIRQ       = 8,
  parameter int STAB_TICKS = 4,
  parameter int CYC_DIV    = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cfg_wr,
  input  logic [CFG_W-1:0]        cfg_data,
  input  logic                    hold_req,
  input  logic                    stop_req,
  input  logic [PORT_W*NPORT-1:0] port_wake,
  input  logic [PORT_W*NPORT-1:0] port_wake_en,
  input  logic [NIRQ-1:0]         irq_req,
  input  logic [NIRQ-1:0]         irq_en,
  input  logic                    main_tick,
  input  logic                    sub_tick,
  output logic                    main_osc_en,
  output logic                    sub_osc_en,
  output logic                    sys_sel_sub,
  output logic                    xtal_mode,
  output logic                    cpu_clk_en,
  output logic                    cyc_en,
  output logic                    wake_pulse
);
  logic [NPORT-1:0] port_hit_v;
  logic main_en;

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    assign port_hit_v[p] = |(port_wake[p*PORT_W +: PORT_W] & port_wake_en[p*PORT_W +: PORT_W]);
  end

  pcc_cfg u_cfg (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (cfg_wr & cpu_clk_en),
    .wr_data (cfg_data),
    .sel_sub (sys_sel_sub),
    .main_en (main_en),
    .xtal    (xtal_mode)
  );

  pcc_seq #(.STAB_TICKS(STAB_TICKS)) u_seq (
    .clk         (clk),
    .rst         (rst),
    .hold_req    (hold_req),
    .stop_req    (stop_req),
    .port_hit    (|port_hit_v),
    .irq_hit     (|(irq_req & irq_en)),
    .sel_sub     (sys_sel_sub),
    .main_en     (main_en),
    .main_tick   (main_tick),
    .sub_tick    (sub_tick),
    .main_osc_en (main_osc_en),
    .sub_osc_en  (sub_osc_en),
    .cpu_clk_en  (cpu_clk_en),
    .wake_pulse  (wake_pulse)
  );

  pcc_cycdiv #(.CYC_DIV(CYC_DIV)) u_div (
    .clk      (clk),
    .rst      (rst),
    .run      (cpu_clk_en),
    .sys_tick (sys_sel_sub ? sub_tick : main_tick),
    .cyc_en   (cyc_en)
  );

  // R6
  hold_no_port_chk: assert property (@(posedge clk) disable iff (rst)
    (!cpu_clk_en && sub_osc_en && !wake_pulse && !main_osc_en && (irq_req & irq_en) == '0
     && !$past(cpu_clk_en)) |=> !wake_pulse);
endmodule

// File: tb/test_pwr_clk_ctrl.sv
module test_pwr_clk_ctrl;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_wr = 1'b0;
  logic [2:0] cfg_data = '0;
  logic hold_req = 1'b0, stop_req = 1'b0;
  logic [7:0] port_wake = '0, port_wake_en = '0, irq_req = '0, irq_en = '0;
  logic main_tick = 1'b0, sub_tick = 1'b0;
  logic main_osc_en, sub_osc_en, sys_sel_sub, xtal_mode, cpu_clk_en, cyc_en, wake_pulse;
  int errors = 0, checks = 0;

  always #4 clk = ~clk;

  pwr_clk_ctrl i_pwr_clk_ctrl (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_data(cfg_data),
    .hold_req(hold_req), .stop_req(stop_req),
    .port_wake(port_wake), .port_wake_en(port_wake_en),
    .irq_req(irq_req), .irq_en(irq_en),
    .main_tick(main_tick), .sub_tick(sub_tick),
    .main_osc_en(main_osc_en), .sub_osc_en(sub_osc_en), .sys_sel_sub(sys_sel_sub),
    .xtal_mode(xtal_mode), .cpu_clk_en(cpu_clk_en), .cyc_en(cyc_en), .wake_pulse(wake_pulse)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic write_cfg(input logic [2:0] v);
    @(negedge clk); cfg_data = v; cfg_wr = 1'b1;
    @(negedge clk); cfg_wr = 1'b0;
    @(negedge clk);
  endtask

  // one tick pulse; returns at the negedge after the sampling edge
  task automatic tick(input logic use_sub);
    @(negedge clk); if (use_sub) sub_tick = 1'b1; else main_tick = 1'b1;
    @(negedge clk); sub_tick = 1'b0; main_tick = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 cpu_clk_en", cpu_clk_en, 1'b1);
    chk("R1 main_osc_en", main_osc_en, 1'b1);
    chk("R1 sub_osc_en", sub_osc_en, 1'b1);
    chk("R1 sys_sel_sub", sys_sel_sub, 1'b0);
    chk("R1 xtal_mode", xtal_mode, 1'b0);
    chk("R1 wake_pulse", wake_pulse, 1'b0);
    chk("R1 cyc_en", cyc_en, 1'b0);
  endtask

  task automatic t_cfg;
    write_cfg(3'b101);
    chk("R2 select sub", sys_sel_sub, 1'b1);
    chk("R2 crystal", xtal_mode, 1'b1);
    chk("R3 main off with sub selected", main_osc_en, 1'b0);
    write_cfg(3'b000);
    chk("R2 select main", sys_sel_sub, 1'b0);
    chk("R2 rc mode", xtal_mode, 1'b0);
    chk("R3 clear ignored on main", main_osc_en, 1'b1);
  endtask

  task automatic t_cycle;
    for (int i = 1; i <= 4; i++) begin
      tick(1'b0);
      chk("R4 cyc after main tick", cyc_en, (i == 4));
    end
    @(negedge clk);
    chk("R4 cyc one cycle", cyc_en, 1'b0);
    for (int i = 0; i < 4; i++) begin
      tick(1'b1);
      chk("R4 unselected tick ignored", cyc_en, 1'b0);
    end
  endtask

  task automatic t_hold;
    irq_en = 8'h04;
    port_wake_en = 8'hFF;
    @(negedge clk); hold_req = 1'b1;
    @(negedge clk); hold_req = 1'b0;
    chk("R5 cpu gated", cpu_clk_en, 1'b0);
    chk("R5 main off", main_osc_en, 1'b0);
    chk("R5 sub on", sub_osc_en, 1'b1);
    irq_req = 8'h01;
    @(negedge clk); irq_req = '0;
    @(negedge clk);
    chk("R6 masked irq no wake", wake_pulse, 1'b0);
    port_wake = 8'h10;
    @(negedge clk); port_wake = '0;
    @(negedge clk);
    chk("R6 port no hold wake", wake_pulse, 1'b0);
    chk("R6 still held", cpu_clk_en, 1'b0);
    irq_req = 8'h04;
    @(negedge clk); irq_req = '0;
    chk("R8 wake pulse", wake_pulse, 1'b1);
    chk("R8 main back on", main_osc_en, 1'b1);
    @(negedge clk);
    chk("R8 pulse one cycle", wake_pulse, 1'b0);
    for (int i = 1; i <= 4; i++) begin
      tick(1'b0);
      chk("R9 gate after stab ticks", cpu_clk_en, (i == 4));
    end
  endtask

  task automatic t_stop;
    write_cfg(3'b001);
    irq_en = 8'hFF;
    port_wake_en = 8'h40;
    @(negedge clk); stop_req = 1'b1;
    @(negedge clk); stop_req = 1'b0;
    chk("R7 cpu gated", cpu_clk_en, 1'b0);
    chk("R7 main off", main_osc_en, 1'b0);
    chk("R7 sub off", sub_osc_en, 1'b0);
    irq_req = 8'hFF;
    @(negedge clk); irq_req = '0;
    @(negedge clk);
    chk("R7 irq no stop wake", sub_osc_en, 1'b0);
    port_wake = 8'h0F;
    @(negedge clk); port_wake = '0;
    @(negedge clk);
    chk("R7 masked port no wake", sub_osc_en, 1'b0);
    port_wake = 8'h40;
    @(negedge clk); port_wake = '0;
    chk("R8 stop wake pulse", wake_pulse, 1'b1);
    chk("R8 sub restarted", sub_osc_en, 1'b1);
    chk("R8 main follows cfg", main_osc_en, 1'b0);
    for (int i = 0; i < 4; i++) begin
      tick(1'b0);
      chk("R9 other clock not counted", cpu_clk_en, 1'b0);
    end
    for (int i = 1; i <= 4; i++) begin
      tick(1'b1);
      chk("R9 sub stab count", cpu_clk_en, (i == 4));
    end
  endtask

  task automatic t_prio;
    port_wake_en = 8'h01;
    @(negedge clk); stop_req = 1'b1; hold_req = 1'b1;
    @(negedge clk); stop_req = 1'b0; hold_req = 1'b0;
    chk("R10 stop wins", sub_osc_en, 1'b0);
    cfg_data = 3'b110; cfg_wr = 1'b1;
    @(negedge clk); cfg_wr = 1'b0;
    port_wake = 8'h01;
    @(negedge clk); port_wake = '0;
    for (int i = 0; i < 4; i++) tick(1'b1);
    chk("R11 resumed", cpu_clk_en, 1'b1);
    chk("R11 select unchanged", sys_sel_sub, 1'b1);
    chk("R11 crystal unchanged", xtal_mode, 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset;
    t_cfg;
    t_cycle;
    t_hold;
    t_stop;
    t_prio;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule